// File: doc/BRIEF.md
# Multiplexed Address/Data Bus Cycle Generator

This block is a bus master. It takes one memory or I/O access at a time from an internal requester and carries it out as one or two cycles on a shared bus. On that bus the low sixteen address bits and the data share the same sixteen lines, and the top four address bits share their lines with processor status. Each cycle starts with a clock that presents the full 20-bit address and pulses an address-latch strobe, so that external latches can hold the address. After that clock the shared lines carry data and status. Byte lanes are chosen by an active-low high-byte enable together with address bit 0.

A request gives an address, a byte or word size, a direction, write data, a two-bit segment code and the current interrupt-enable flag. The block samples a request only while it is idle. It returns the read data together with a one-clock done pulse.

The cycle engine has the states IDLE, T1, T2, T3, TW and T4, with these transitions:
- IDLE→T1 when a request is accepted.
- T1→T2, then T2→T3.
- T3→T4 or TW→T4 when READY is high.
- T3→TW or TW→TW while READY is low.
- T4→T1 when a second byte cycle is still owed.
- T4→IDLE after the final byte cycle.

Top module: `mux_bus_master`

## Requirements
- R1: During T1 only, `ale` is 1, `ad_oe` is 1, `ad_out` equals address bits 15:0 and `a_st` equals address bits 19:16 of the current byte cycle. `ale` is 0 in every other state.
- R2: In T2, T3, TW and T4, `a_st[3]` (S6) is 0, `a_st[2]` (S5) equals the request's interrupt-enable flag, and `bhe_st` carries status S7, which is driven 0.
- R3: In T2, T3, TW and T4, `a_st[1:0]` (S4,S3) equals the request's segment code: 00 extra, 01 stack, 10 code or none, 11 data.
- R4: Single-cycle lane selection in T1 is as follows. An even word gives `bhe_st`=0 and uses all sixteen lines. An even byte gives `bhe_st`=1 and uses lines 7:0. An odd byte gives `bhe_st`=0 and uses lines 15:8.
- R5: A word at an odd address A takes two byte cycles. The first has address A, `bhe_st`=0, and carries the low byte on lines 15:8. The second has address A+1 (modulo 2^20), `bhe_st`=1, and carries the high byte on lines 7:0.
- R6: For a read, `rd_n` is 0 in T2, T3 and TW and 1 everywhere else, and `ad_oe` is 0 from T2 through T4.
- R7: For a write, `ad_oe` is 1 from T1 through T4. From T2 to T4, `ad_out` holds the write byte(s) on the used lane, and any unused lane is driven 0.
- R8: With READY high at T3, a byte cycle lasts exactly four clocks. Each clock of READY low at T3 or TW adds one TW state, and TW holds the bus outputs of T3.
- R9: Read data is sampled from `ad_in` on the clock edge that leaves T3 or TW with READY high. A byte read returns its byte in `rsp_rdata[7:0]` with bits 15:8 set to 0. A word read returns the full word, and for an odd address it is assembled from both byte cycles.
- R10: `rsp_done` is 1 for exactly one clock, the clock after the final T4. `rsp_rdata` is valid in that clock.
- R11: `req_valid` is ignored unless the engine is IDLE. A request raised during a cycle starts no further bus cycle.
- R12: While and after reset the block is IDLE: `ale`=0, `rd_n`=1, `ad_oe`=0, `bhe_st`=1, `a_st`=0 and `rsp_done`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Request present, sampled in IDLE |
| req_addr | input | 20 | Byte address |
| req_word | input | 1 | 1 = word, 0 = byte |
| req_write | input | 1 | 1 = write, 0 = read |
| req_wdata | input | 16 | Write data (byte in bits 7:0) |
| req_seg | input | 2 | Segment code shown on S4,S3 |
| req_ie | input | 1 | Interrupt-enable flag shown on S5 |
| rsp_rdata | output | 16 | Read data |
| rsp_done | output | 1 | One-clock completion pulse |
| ad_out | output | 16 | Multiplexed address/data out |
| ad_oe | output | 1 | Output enable for ad_out |
| ad_in | input | 16 | Multiplexed data in |
| a_st | output | 4 | Address 19:16 in T1, status S6..S3 after |
| bhe_st | output | 1 | High-byte enable (active low) in T1, S7 after |
| rd_n | output | 1 | Read strobe, active low |
| ale | output | 1 | Address-latch strobe |
| ready | input | 1 | Cycle may complete when high |

## Verification
The bench targets the odd-address word. A design that forgets to split it would finish in one cycle on the wrong lanes. A design that forgets the increment or the lane swap would put the wrong address or byte in the second cycle. Long and irregular READY-low runs test whether data is sampled on the correct edge; a design that samples too early returns stale bus data. The address 0xFFFFF tests wrap-around of the second address. Requests raised mid-cycle test whether a sloppy acceptance condition launches a spurious cycle. All four segment codes with both flag values test status lines that are swapped or stuck.

// File: rtl/mbus_pkg.sv
package mbus_pkg;

    typedef enum logic [2:0] {
        TS_IDLE,
        TS_T1,
        TS_T2,
        TS_T3,
        TS_TW,
        TS_T4
    } tstate_t;

    // which request byte travels on which half of the data lines
    typedef enum logic [1:0] {
        LN_FULL,    // both bytes, natural order
        LN_B0_LO,   // request byte 0 on the low lane
        LN_B0_HI,   // request byte 0 on the high lane
        LN_B1_LO    // request byte 1 on the low lane
    } lane_t;

    localparam logic S7_LEVEL = 1'b0;

endpackage

// File: rtl/mbus_split.sv
module mbus_split
    import mbus_pkg::*;
#(
    parameter int ADDR_W = 20
) (
    input  logic [ADDR_W-1:0] base_addr,
    input  logic              is_word,
    input  logic              part,
    output logic [ADDR_W-1:0] cyc_addr,
    output logic              cyc_bhe_n,
    output lane_t             lane,
    output logic              last_part
);

    logic odd;

    assign odd       = base_addr[0];
    assign last_part = !(is_word && odd) || part;
    assign cyc_addr  = base_addr + ADDR_W'(part);

    always_comb begin
        if (!is_word) begin
            cyc_bhe_n = ~odd;
            lane      = odd ? LN_B0_HI : LN_B0_LO;
        end else if (!odd) begin
            cyc_bhe_n = 1'b0;
            lane      = LN_FULL;
        end else if (!part) begin
            cyc_bhe_n = 1'b0;
            lane      = LN_B0_HI;
        end else begin
            cyc_bhe_n = 1'b1;
            lane      = LN_B1_LO;
        end
    end

endmodule

// File: rtl/mbus_tseq.sv
module mbus_tseq
    import mbus_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    start,
    input  logic    ready,
    input  logic    last_part,
    output tstate_t state,
    output logic    part,
    output logic    capture,
    output logic    finish
);

    tstate_t nxt;

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= TS_IDLE;
        end else begin
            state <= nxt;
        end
    end

    always_comb begin
        nxt = state;
        unique case (state)
            TS_IDLE: if (start) nxt = TS_T1;
            TS_T1:   nxt = TS_T2;
            TS_T2:   nxt = TS_T3;
            TS_T3,
            TS_TW:   nxt = ready ? TS_T4 : TS_TW;
            TS_T4:   nxt = last_part ? TS_IDLE : TS_T1;
            default: nxt = TS_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            part <= 1'b0;
        end else if (start) begin
            part <= 1'b0;
        end else if (state == TS_T4) begin
            part <= !last_part;
        end
    end

    assign capture = ((state == TS_T3) || (state == TS_TW)) && ready;
    assign finish  = (state == TS_T4) && last_part;

    // R8: fixed progression through the first states
    a_r8_t1_then_t2: assert property (@(posedge clk) disable iff (rst)
        state == TS_T1 |=> state == TS_T2);
    // R8: low READY holds the cycle in wait states
    a_r8_wait_on_low: assert property (@(posedge clk) disable iff (rst)
        ((state == TS_T3 || state == TS_TW) && !ready) |=> state == TS_TW);
    // R8: high READY ends the cycle one clock later
    a_r8_end_on_high: assert property (@(posedge clk) disable iff (rst)
        ((state == TS_T3 || state == TS_TW) && ready) |=> state == TS_T4);
    // R5: a second part only follows a first one
    a_r5_part_after_t4: assert property (@(posedge clk) disable iff (rst)
        $rose(part) |-> $past(state) == TS_T4);

endmodule

// File: rtl/mbus_rcap.sv
module mbus_rcap
    import mbus_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clear,
    input  logic              capture,
    input  lane_t             lane,
    input  logic [DATA_W-1:0] ad_in,
    output logic [DATA_W-1:0] rdata
);

    localparam int BYTE_W = DATA_W / 2;

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            rdata <= '0;
        end else if (capture) begin
            unique case (lane)
                LN_FULL:  rdata <= ad_in;
                LN_B0_LO: rdata[BYTE_W-1:0] <= ad_in[BYTE_W-1:0];
                LN_B0_HI: rdata[BYTE_W-1:0] <= ad_in[DATA_W-1:BYTE_W];
                LN_B1_LO: rdata[DATA_W-1:BYTE_W] <= ad_in[BYTE_W-1:0];
                default:  rdata <= rdata;
            endcase
        end
    end

    // R9: an idle capture leaves the data alone
    a_r9_hold_without_capture: assert property (@(posedge clk) disable iff (rst)
        (!capture && !clear) |=> $stable(rdata));

endmodule

// File: rtl/mux_bus_master.sv
module mux_bus_master
    import mbus_pkg::*;
#(
    parameter int ADDR_W = 20,
    parameter int DATA_W = 16
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     req_valid,
    input  logic [ADDR_W-1:0]        req_addr,
    input  logic                     req_word,
    input  logic                     req_write,
    input  logic [DATA_W-1:0]        req_wdata,
    input  logic [1:0]               req_seg,
    input  logic                     req_ie,
    output logic [DATA_W-1:0]        rsp_rdata,
    output logic                     rsp_done,
    output logic [DATA_W-1:0]        ad_out,
    output logic                     ad_oe,
    input  logic [DATA_W-1:0]        ad_in,
    output logic [ADDR_W-DATA_W-1:0] a_st,
    output logic                     bhe_st,
    output logic                     rd_n,
    output logic                     ale,
    input  logic                     ready
);

    localparam int HI_W   = ADDR_W - DATA_W;
    localparam int BYTE_W = DATA_W / 2;

    tstate_t           state;
    logic              part;
    logic              capture;
    logic              finish;
    logic              start;
    logic              last_part;
    logic [ADDR_W-1:0] cyc_addr;
    logic              cyc_bhe_n;
    lane_t             lane;

    logic [ADDR_W-1:0] addr_q;
    logic              word_q;
    logic              wr_q;
    logic [DATA_W-1:0] wd_q;
    logic [1:0]        seg_q;
    logic              ie_q;
    logic              done_q;
    logic [DATA_W-1:0] lane_wdata;
    logic [HI_W-1:0]   status;

    assign start = req_valid && (state == TS_IDLE);

    always_ff @(posedge clk) begin
        if (rst) begin
            addr_q <= '0;
            word_q <= 1'b0;
            wr_q   <= 1'b0;
            wd_q   <= '0;
            seg_q  <= 2'b00;
            ie_q   <= 1'b0;
        end else if (start) begin
            addr_q <= req_addr;
            word_q <= req_word;
            wr_q   <= req_write;
            wd_q   <= req_wdata;
            seg_q  <= req_seg;
            ie_q   <= req_ie;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            done_q <= 1'b0;
        end else begin
            done_q <= finish;
        end
    end

    mbus_split #(.ADDR_W(ADDR_W)) u_split (
        .base_addr (addr_q),
        .is_word   (word_q),
        .part      (part),
        .cyc_addr  (cyc_addr),
        .cyc_bhe_n (cyc_bhe_n),
        .lane      (lane),
        .last_part (last_part)
    );

    mbus_tseq u_tseq (
        .clk       (clk),
        .rst       (rst),
        .start     (start),
        .ready     (ready),
        .last_part (last_part),
        .state     (state),
        .part      (part),
        .capture   (capture),
        .finish    (finish)
    );

    mbus_rcap #(.DATA_W(DATA_W)) u_rcap (
        .clk     (clk),
        .rst     (rst),
        .clear   (start),
        .capture (capture && !wr_q),
        .lane    (lane),
        .ad_in   (ad_in),
        .rdata   (rsp_rdata)
    );

    always_comb begin
        lane_wdata = '0;
        unique case (lane)
            LN_FULL:  lane_wdata = wd_q;
            LN_B0_LO: lane_wdata[BYTE_W-1:0] = wd_q[BYTE_W-1:0];
            LN_B0_HI: lane_wdata[DATA_W-1:BYTE_W] = wd_q[BYTE_W-1:0];
            LN_B1_LO: lane_wdata[BYTE_W-1:0] = wd_q[DATA_W-1:BYTE_W];
            default:  lane_wdata = '0;
        endcase
    end

    always_comb begin
        status    = '0;
        status[0] = seg_q[0];
        status[1] = seg_q[1];
        status[2] = ie_q;
    end

    always_comb begin
        ad_out = '0;
        ad_oe  = 1'b0;
        a_st   = '0;
        bhe_st = 1'b1;
        rd_n   = 1'b1;
        ale    = 1'b0;
        unique case (state)
            TS_IDLE: begin
            end
            TS_T1: begin
                ale    = 1'b1;
                ad_oe  = 1'b1;
                ad_out = cyc_addr[DATA_W-1:0];
                a_st   = cyc_addr[ADDR_W-1:DATA_W];
                bhe_st = cyc_bhe_n;
            end
            TS_T2, TS_T3, TS_TW: begin
                a_st   = status;
                bhe_st = S7_LEVEL;
                ad_oe  = wr_q;
                ad_out = wr_q ? lane_wdata : '0;
                rd_n   = wr_q;
            end
            TS_T4: begin
                a_st   = status;
                bhe_st = S7_LEVEL;
                ad_oe  = wr_q;
                ad_out = wr_q ? lane_wdata : '0;
            end
            default: begin
            end
        endcase
    end

    assign rsp_done = done_q;

    // R1: the latch strobe never overlaps a read strobe and always drives the lines
    a_r1_ale_drives_addr: assert property (@(posedge clk) disable iff (rst)
        ale |-> (ad_oe && rd_n));
    // R1: the latch strobe lasts a single clock
    a_r1_ale_one_clock: assert property (@(posedge clk) disable iff (rst)
        ale |=> !ale);
    // R6: the read strobe only while the lines are released
    a_r6_read_floats: assert property (@(posedge clk) disable iff (rst)
        !rd_n |-> !ad_oe);
    // R10: completion is a single pulse
    a_r10_done_single: assert property (@(posedge clk) disable iff (rst)
        rsp_done |=> !rsp_done);
    // R11: the latched request is untouched while busy
    a_r11_busy_holds_request: assert property (@(posedge clk) disable iff (rst)
        (state != TS_IDLE) |=> ($stable(addr_q) && $stable(wr_q) && $stable(word_q)));
    // R7: a write keeps the lines driven for the whole cycle
    a_r7_write_drives: assert property (@(posedge clk) disable iff (rst)
        (state != TS_IDLE && wr_q) |-> ad_oe);

endmodule

// File: tb/sim_mux_bus_master.sv
module sim_mux_bus_master;

    localparam int CLK_P = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic [19:0] req_addr = '0;
    logic        req_word = 1'b0;
    logic        req_write = 1'b0;
    logic [15:0] req_wdata = '0;
    logic [1:0]  req_seg = 2'b00;
    logic        req_ie = 1'b0;
    logic [15:0] rsp_rdata;
    logic        rsp_done;
    logic [15:0] ad_out;
    logic        ad_oe;
    logic [15:0] ad_in = 16'hACE1;
    logic [3:0]  a_st;
    logic        bhe_st;
    logic        rd_n;
    logic        ale;
    logic        ready = 1'b1;

    always #(CLK_P/2) clk = ~clk;

    mux_bus_master u0 (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_addr(req_addr),
        .req_word(req_word), .req_write(req_write), .req_wdata(req_wdata),
        .req_seg(req_seg), .req_ie(req_ie), .rsp_rdata(rsp_rdata),
        .rsp_done(rsp_done), .ad_out(ad_out), .ad_oe(ad_oe), .ad_in(ad_in),
        .a_st(a_st), .bhe_st(bhe_st), .rd_n(rd_n), .ale(ale), .ready(ready)
    );

    int n_vec = 0;
    int n_bad = 0;
    int ready_mode = 0;
    int tick = 0;
    bit finished = 0;

    // reference model: phase 0 idle, 1..4 base clocks, 5 wait
    int          ph = 0;
    int          part = 0;
    int          nparts = 0;
    logic [19:0] d_addr [2];
    logic        d_bhe [2];
    int          d_lane [2];   // 0 word, 1 b0 low, 2 b0 high, 3 b1 low
    logic        m_wr = 1'b0;
    logic [15:0] m_wd = '0;
    logic [15:0] m_rd = '0;
    logic [1:0]  m_seg = 2'b00;
    logic        m_ie = 1'b0;
    logic        m_done = 1'b0;

    task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp, input string what);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s at t=%0t: actual %h expected %h", rq, what, $time, act, exp);
        end
    endtask

    task automatic plan(input logic [19:0] a, input logic w);
        if (!w) begin
            nparts = 1; d_addr[0] = a; d_bhe[0] = ~a[0]; d_lane[0] = a[0] ? 2 : 1;
        end else if (!a[0]) begin
            nparts = 1; d_addr[0] = a; d_bhe[0] = 1'b0; d_lane[0] = 0;
        end else begin
            nparts = 2;
            d_addr[0] = a;        d_bhe[0] = 1'b0; d_lane[0] = 2;
            d_addr[1] = a + 20'd1; d_bhe[1] = 1'b1; d_lane[1] = 3;
        end
    endtask

    function automatic logic [15:0] expw(input int ln, input logic [15:0] wd);
        case (ln)
            0: return wd;
            1: return {8'h00, wd[7:0]};
            2: return {wd[7:0], 8'h00};
            default: return {8'h00, wd[15:8]};
        endcase
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            ph = 0; part = 0; nparts = 0; m_done = 1'b0; m_rd = '0;
        end else begin
            m_done = 1'b0;
            case (ph)
                0: if (req_valid) begin
                    m_wr = req_write; m_wd = req_wdata; m_seg = req_seg; m_ie = req_ie;
                    m_rd = '0; part = 0; plan(req_addr, req_word); ph = 1;
                end
                1: ph = 2;
                2: ph = 3;
                3, 5: if (ready) begin
                    if (!m_wr) begin
                        case (d_lane[part])
                            0: m_rd = ad_in;
                            1: m_rd[7:0] = ad_in[7:0];
                            2: m_rd[7:0] = ad_in[15:8];
                            default: m_rd[15:8] = ad_in[7:0];
                        endcase
                    end
                    ph = 4;
                end else begin
                    ph = 5;
                end
                4: if (part + 1 < nparts) begin
                    part++; ph = 1;
                end else begin
                    ph = 0; m_done = 1'b1;
                end
                default: ph = 0;
            endcase
        end
    end

    task automatic compare_all();
        chk("R1", 32'(ale), 32'(ph == 1), "ale");
        chk("R10", 32'(rsp_done), 32'(m_done), "done");
        if (m_done) chk("R9", 32'(rsp_rdata), 32'(m_rd), "rdata");
        if (ph == 0) begin
            chk("R12", {ad_oe, rd_n, bhe_st, a_st}, {1'b0, 1'b1, 1'b1, 4'h0}, "idle pins");
        end else if (ph == 1) begin
            chk("R1", 32'(ad_oe), 32'd1, "oe in T1");
            chk("R1", 32'(ad_out), 32'(d_addr[part][15:0]), "low address");
            chk("R1", 32'(a_st), 32'(d_addr[part][19:16]), "high address");
            chk(nparts == 2 ? "R5" : "R4", 32'(bhe_st), 32'(d_bhe[part]), "high byte enable");
        end else begin
            chk("R2", {a_st[3:2], bhe_st}, {1'b0, m_ie, 1'b0}, "S6 S5 S7");
            chk("R3", 32'(a_st[1:0]), 32'(m_seg), "segment code");
            chk("R6", 32'(ad_oe), 32'(m_wr), "oe after T1");
            chk("R6", 32'(rd_n), 32'(m_wr || ph == 4), "read strobe");
            if (m_wr) chk("R7", 32'(ad_out), 32'(expw(d_lane[part], m_wd)), "write lanes");
            if (ph == 5) chk("R8", 32'(ale), 32'd0, "wait holds");
        end
    endtask

    initial begin
        forever begin
            @(posedge clk);
            #(CLK_P/4);
            if (!rst && !finished) compare_all();
        end
    end

    // bus-side stimulus: changing read data and READY pattern
    initial begin
        forever begin
            @(negedge clk);
            ad_in = {ad_in[14:0], ad_in[15] ^ ad_in[13] ^ ad_in[12] ^ ad_in[10]};
            tick++;
            if (ready_mode == 0) ready = 1'b1;
            else if (ready_mode == 1) ready = (tick % 3) == 2;
            else ready = (tick % 7) == 0;
        end
    end

    task automatic issue(input logic [19:0] a, input logic w, input logic wr,
                         input logic [15:0] d, input logic [1:0] s, input logic e, input bit junk);
        @(negedge clk);
        while (ph != 0) @(negedge clk);
        req_valid = 1'b1; req_addr = a; req_word = w; req_write = wr;
        req_wdata = d; req_seg = s; req_ie = e;
        @(negedge clk);
        req_valid = 1'b0;
        if (junk) begin
            // R11: request raised while busy
            req_valid = 1'b1; req_addr = 20'h12345; req_write = ~wr;
            @(negedge clk);
            @(negedge clk);
            req_valid = 1'b0;
        end
        while (ph != 0) @(negedge clk);
    endtask

    initial begin
        repeat (5) @(negedge clk);
        // R12: reset state
        chk("R12", {ale, rd_n, ad_oe, bhe_st, rsp_done}, {1'b0, 1'b1, 1'b0, 1'b1, 1'b0}, "in reset");
        rst = 1'b0;
        @(negedge clk);
        chk("R12", {ale, rd_n, ad_oe, bhe_st, a_st}, {1'b0, 1'b1, 1'b0, 1'b1, 4'h0}, "after reset");

        // R4 single cycles with READY high
        issue(20'h01234, 1, 0, 16'h0000, 2'b11, 1, 0);
        issue(20'h01234, 1, 1, 16'hBEEF, 2'b10, 0, 0);
        issue(20'h0A002, 0, 0, 16'h0000, 2'b00, 1, 0);
        issue(20'h0A002, 0, 1, 16'h7755, 2'b01, 0, 0);
        issue(20'hF0013, 0, 0, 16'h0000, 2'b11, 0, 0);
        issue(20'hF0013, 0, 1, 16'h66AA, 2'b10, 1, 0);
        // R5 odd words, incl. wrap at the top of memory
        issue(20'h54321, 1, 0, 16'h0000, 2'b01, 1, 0);
        issue(20'h54321, 1, 1, 16'hC3A5, 2'b00, 0, 0);
        issue(20'hFFFFF, 1, 0, 16'h0000, 2'b11, 1, 0);
        issue(20'hFFFFF, 1, 1, 16'h1298, 2'b10, 0, 0);
        // R3 every segment code with both flag values
        for (int s = 0; s < 4; s++) begin
            issue(20'h30000 + 20'(s * 2), 1, s[0], 16'h1111 * 16'(s + 1), 2'(s), s[1], 0);
        end
        // R8 wait states, short and long
        ready_mode = 1;
        issue(20'h22222, 1, 0, 16'h0000, 2'b10, 1, 0);
        issue(20'h22223, 1, 0, 16'h0000, 2'b01, 0, 0);
        issue(20'h22223, 1, 1, 16'h9A8B, 2'b11, 1, 0);
        ready_mode = 2;
        issue(20'h40001, 0, 0, 16'h0000, 2'b00, 0, 0);
        issue(20'h40005, 1, 0, 16'h0000, 2'b11, 1, 0);
        issue(20'h40006, 0, 1, 16'h00F0, 2'b01, 1, 0);
        ready_mode = 0;
        // R11 request while busy starts nothing
        issue(20'h08888, 1, 0, 16'h0000, 2'b11, 0, 1);
        repeat (3) begin
            @(negedge clk);
            chk("R11", {ale, ad_oe}, 2'b00, "no spurious cycle");
        end
        ready_mode = 1;
        issue(20'h08889, 1, 1, 16'h4321, 2'b10, 1, 1);
        repeat (3) begin
            @(negedge clk);
            chk("R11", {ale, ad_oe}, 2'b00, "no spurious cycle");
        end
        repeat (2) @(negedge clk);
        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        repeat (50000) @(posedge clk);
        finished = 1;
        n_vec++;
        n_bad++;
        $display("FAIL watchdog: actual hung expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule